// File: doc/BRIEF.md
# Write-Through Register File

This block holds the general-purpose integer registers of a five-stage in-order pipeline. The decode stage reads two source operands in the same cycle through two combinational read ports. The write-back stage retires one result per cycle through a single port that is clocked on the rising edge.

When write-back targets a register that decode is reading in the same cycle, each read port returns the value being written rather than the stale stored word. Decode therefore never stalls for that overlap. Register 0 is a constant zero: it reads as zero on either port, and any write aimed at it is dropped. A synchronous active-high reset clears every register.

Top module: `wt_regfile`

## Requirements
- R1: While `rst` is high at a rising edge, every register is cleared, so that afterwards both read ports return 0 for every index until a new write lands.
- R2: With `wr_en` high and a non-zero `wr_idx`, `wr_word` is stored at the rising edge and is returned by a read of that index in every later cycle until it is overwritten.
- R3: With `wr_en` low, no register changes at the clock edge, whatever `wr_idx` and `wr_word` carry.
- R4: A read of index 0 returns 0 on either port, and a write to index 0 leaves it reading 0 in later cycles.
- R5: When `wr_en` is high and `wr_idx` equals a non-zero `src_a_idx`, `src_a_word` equals `wr_word` in that same cycle.
- R6: When `wr_en` is high and `wr_idx` equals a non-zero `src_b_idx`, `src_b_word` equals `wr_word` in that same cycle.
- R7: When both read ports select the same index, they return identical words.
- R8: A write to index 0 in the same cycle as a read of index 0 does not bypass: the read still returns 0.
- R9: A write to one index leaves the contents of every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset that clears all registers |
| src_a_idx | input | 5 | Register index for read port A |
| src_b_idx | input | 5 | Register index for read port B |
| src_a_word | output | 32 | Combinational read data for port A |
| src_b_word | output | 32 | Combinational read data for port B |
| wr_en | input | 1 | Write enable from write-back |
| wr_idx | input | 5 | Destination register index |
| wr_word | input | 32 | Data to be written |

## Verification
Each read result is due in the same cycle that its index is presented, so the bench drives indices and write controls just after a rising edge and samples both read ports at the following falling edge. A write has two visible effects: the bypassed value appears in that same cycle, and the stored value appears from the next cycle on. The bench folds the write into its reference array only once the rising edge has passed. Expected words are queued by the driver when it drives a cycle. The monitor pops and compares them at the falling edge of that same cycle, so no comparison ever straddles a clock edge.

// File: rtl/rf_pkg.sv
package rf_pkg;
  // Default geometry of the integer register file.
  parameter int RF_DEPTH = 32;
  parameter int RF_WIDTH = 32;
  parameter int RF_READS = 2;
endpackage

// File: rtl/rf_storage.sv
// Storage array: one synchronous write port, NUM_RD asynchronous raw read ports.
// Index 0 is never written, so after reset it holds zero.
module rf_storage #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  parameter int NUM_RD   = 2,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_idx,
  input  logic [DATA_W-1:0]              wr_word,
  input  logic [NUM_RD-1:0][ADDR_W-1:0]  rd_idx,
  output logic [NUM_RD-1:0][DATA_W-1:0]  rd_raw
);

  logic [DATA_W-1:0] mem [NUM_REGS];
  logic              wr_live;

  assign wr_live = wr_en && (wr_idx != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) begin
        mem[i] <= '0;
      end
    end else if (wr_live) begin
      mem[wr_idx] <= wr_word;
    end
  end

  for (genvar p = 0; p < NUM_RD; p++) begin : g_raw
    assign rd_raw[p] = mem[rd_idx[p]];
  end

  // R2: a live write lands in the addressed entry.
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    wr_live |=> mem[$past(wr_idx)] == $past(wr_word));

  // R4: entry 0 stays zero once out of reset.
  p_entry0_zero_r4: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> mem[0] == '0);

endmodule

// File: rtl/rf_rd_port.sv
// One read port: forwards a same-cycle write and forces index 0 to zero.
module rf_rd_port #(
  parameter int NUM_REGS = 32,
  parameter int DATA_W   = 32,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] rd_idx,
  input  logic [DATA_W-1:0] stored_word,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_word
);

  logic idx_zero;
  logic hit;

  assign idx_zero = (rd_idx == '0);
  assign hit      = wr_en && (wr_idx == rd_idx) && !idx_zero;

  always_comb begin
    if (idx_zero)  rd_word = '0;
    else if (hit)  rd_word = wr_word;
    else           rd_word = stored_word;
  end

  // R8: writing index 0 never forwards into a read of index 0.
  p_no_zero_fwd_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == '0 && idx_zero) |-> rd_word == '0);

endmodule

// File: rtl/wt_regfile.sv
// Register file with write-through bypass and a hardwired zero register.
module wt_regfile #(
  parameter int NUM_REGS = rf_pkg::RF_DEPTH,
  parameter int DATA_W   = rf_pkg::RF_WIDTH,
  localparam int ADDR_W  = $clog2(NUM_REGS),
  localparam int NUM_RD  = rf_pkg::RF_READS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] src_a_idx,
  input  logic [ADDR_W-1:0] src_b_idx,
  output logic [DATA_W-1:0] src_a_word,
  output logic [DATA_W-1:0] src_b_word,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_idx,
  input  logic [DATA_W-1:0] wr_word
);

  logic [NUM_RD-1:0][ADDR_W-1:0] rd_idx;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_raw;
  logic [NUM_RD-1:0][DATA_W-1:0] rd_word;

  assign rd_idx[0] = src_a_idx;
  assign rd_idx[1] = src_b_idx;

  rf_storage #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .NUM_RD   (NUM_RD)
  ) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_word (wr_word),
    .rd_idx  (rd_idx),
    .rd_raw  (rd_raw)
  );

  for (genvar p = 0; p < NUM_RD; p++) begin : g_port
    rf_rd_port #(
      .NUM_REGS (NUM_REGS),
      .DATA_W   (DATA_W)
    ) u_port (
      .clk         (clk),
      .rst         (rst),
      .rd_idx      (rd_idx[p]),
      .stored_word (rd_raw[p]),
      .wr_en       (wr_en),
      .wr_idx      (wr_idx),
      .wr_word     (wr_word),
      .rd_word     (rd_word[p])
    );
  end

  assign src_a_word = rd_word[0];
  assign src_b_word = rd_word[1];

  // R4: index 0 reads zero on both ports.
  p_zero_read_r4: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == '0 |-> src_a_word == '0) and (src_b_idx == '0 |-> src_b_word == '0));

  // R7: equal indices give equal data.
  p_same_idx_r7: assert property (@(posedge clk) disable iff (rst)
    (src_a_idx == src_b_idx) |-> src_a_word == src_b_word);

  // R3: with no write, a held index keeps its data in the next cycle.
  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ((src_a_idx != $past(src_a_idx)) || (wr_en && wr_idx == src_a_idx)
                || src_a_word == $past(src_a_word)));

  // R5: forwarded word on port A matches what storage holds a cycle later.
  p_fwd_a_r5: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == src_a_idx && wr_idx != '0) |=>
      ((src_a_idx != $past(src_a_idx)) || (wr_en && wr_idx == src_a_idx)
       || src_a_word == $past(src_a_word)));

  // R6: same for port B.
  p_fwd_b_r6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_idx == src_b_idx && wr_idx != '0) |=>
      ((src_b_idx != $past(src_b_idx)) || (wr_en && wr_idx == src_b_idx)
       || src_b_word == $past(src_b_word)));

endmodule

// File: tb/wt_regfile_tb.sv
module wt_regfile_tb;

  localparam int N  = 32;
  localparam int W  = 32;
  localparam int AW = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] src_a_idx = '0;
  logic [AW-1:0] src_b_idx = '0;
  logic [W-1:0]  src_a_word;
  logic [W-1:0]  src_b_word;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_idx = '0;
  logic [W-1:0]  wr_word = '0;

  always #2 clk = ~clk;

  wt_regfile u_dut (
    .clk        (clk),
    .rst        (rst),
    .src_a_idx  (src_a_idx),
    .src_b_idx  (src_b_idx),
    .src_a_word (src_a_word),
    .src_b_word (src_b_word),
    .wr_en      (wr_en),
    .wr_idx     (wr_idx),
    .wr_word    (wr_word)
  );

  typedef struct {
    bit          port_b;
    logic [W-1:0] exp;
    string       req;
  } item_t;

  item_t        sb_q[$];
  logic [W-1:0] model [N];
  int           checks   = 0;
  int           failures = 0;
  bit           done     = 1'b0;

  function automatic logic [W-1:0] predict(logic [AW-1:0] ra, logic we,
                                           logic [AW-1:0] wa, logic [W-1:0] wd);
    if (ra == '0)               return '0;
    if (we && wa == ra)         return wd;
    return model[ra];
  endfunction

  // Driver: one cycle of traffic, expected results pushed before the edge.
  task automatic drive(logic [AW-1:0] ra, logic [AW-1:0] rb, logic we,
                       logic [AW-1:0] wa, logic [W-1:0] wd,
                       string req_a, string req_b);
    item_t it;
    src_a_idx = ra; src_b_idx = rb; wr_en = we; wr_idx = wa; wr_word = wd;
    it.port_b = 1'b0; it.exp = predict(ra, we, wa, wd); it.req = req_a; sb_q.push_back(it);
    it.port_b = 1'b1; it.exp = predict(rb, we, wa, wd); it.req = req_b; sb_q.push_back(it);
    @(posedge clk);
    if (we && wa != '0) model[wa] = wd;
    #1;
  endtask

  task automatic do_reset();
    rst = 1'b1; wr_en = 1'b0;
    @(posedge clk);
    for (int i = 0; i < N; i++) model[i] = '0;
    #1;
    rst = 1'b0;
  endtask

  // Monitor: compare queued expectations at the falling edge.
  always @(negedge clk) begin
    while (sb_q.size() > 0) begin
      item_t it;
      logic [W-1:0] act;
      it  = sb_q.pop_front();
      act = it.port_b ? src_b_word : src_a_word;
      checks++;
      if (act !== it.exp) begin
        failures++;
        $display("FAIL %s port %s actual=%h expected=%h", it.req,
                 it.port_b ? "B" : "A", act, it.exp);
      end
    end
  end

  initial begin
    for (int i = 0; i < N; i++) model[i] = '0;
    repeat (2) @(posedge clk);
    #1;
    do_reset();

    // R1: populate, reset again, then every index reads zero.
    for (int i = 1; i < N; i++) drive(AW'(i), AW'(i), 1'b1, AW'(i), 32'hA500_0000 | i, "R2", "R2");
    do_reset();
    for (int i = 0; i < N; i += 2) drive(AW'(i), AW'(i+1), 1'b0, '0, '0, "R1", "R1");

    // R2: write then read in later cycles.
    drive(5'd3, 5'd0, 1'b1, 5'd3, 32'hDEAD_BEEF, "R4", "R4");
    drive(5'd3, 5'd3, 1'b0, 5'd0, 32'h0, "R2", "R7");

    // R3: disabled write with live-looking address/data.
    drive(5'd3, 5'd9, 1'b0, 5'd3, 32'h1111_2222, "R3", "R3");
    drive(5'd3, 5'd9, 1'b0, 5'd9, 32'h3333_4444, "R3", "R3");

    // R4 / R8: write index 0, read it in the same and the next cycle.
    drive(5'd0, 5'd0, 1'b1, 5'd0, 32'hFFFF_FFFF, "R8", "R8");
    drive(5'd0, 5'd0, 1'b0, 5'd0, 32'h0, "R4", "R4");

    // R5 / R6: same-cycle bypass on each port, and both at once (R7).
    drive(5'd7, 5'd1, 1'b1, 5'd7, 32'h7777_0007, "R5", "R9");
    drive(5'd2, 5'd8, 1'b1, 5'd8, 32'h8888_0008, "R9", "R6");
    drive(5'd31, 5'd31, 1'b1, 5'd31, 32'h1F1F_1F1F, "R5", "R6");
    drive(5'd31, 5'd31, 1'b1, 5'd31, 32'h2E2E_2E2E, "R7", "R7");

    // R9: neighbours of a written index stay intact.
    drive(5'd10, 5'd12, 1'b1, 5'd11, 32'hCAFE_0011, "R9", "R9");
    drive(5'd11, 5'd10, 1'b0, 5'd0, 32'h0, "R2", "R9");

    // Random traffic with a bias toward collisions and index 0.
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] ra, rb, wa;
      logic          we;
      int            mode;
      ra   = AW'($urandom_range(0, N-1));
      rb   = AW'($urandom_range(0, N-1));
      wa   = AW'($urandom_range(0, N-1));
      we   = ($urandom_range(0, 3) != 0);
      mode = $urandom_range(0, 7);
      if (mode == 0) wa = ra;
      if (mode == 1) wa = rb;
      if (mode == 2) begin wa = '0; ra = '0; end
      if (mode == 3) rb = ra;
      drive(ra, rb, we, wa, $urandom(), "R5", "R6");
    end

    @(negedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule